// File: doc/BRIEF.md
# Interrupt Vector Relocation Guard

The guard owns the one control bit that decides whether the interrupt vector table lives in the application area or in the boot loader area. Software cannot flip that bit with a single stray write. It must first write an unlock bit, which opens a short change window. A second write made inside that window loads the new placement. If no such write arrives, the window closes by itself after a fixed number of clocks.

The guard also drives a global interrupt mask. The mask is raised for the whole time the change window is open. It is also raised when a lock input forbids servicing interrupts from the region the processor is running in. Which lock applies depends on the current vector placement.

Both changes go through a single register write port with two data bits: bit 0 is the unlock bit and bit 1 is the placement bit. The lock inputs and the execution-region input are level signals supplied by the surrounding system.

Top module: `ivg_guard`

## Requirements
- R1: After reset, `vec_boot` is 0 (application area) and `win_open` is 0.
- R2: A write with `reg_wdata[0]`=1 makes `win_open` 1 from the next cycle on. That write does not change `vec_boot`.
- R3: With no further write, `win_open` stays 1 for exactly 4 cycles after the unlock write and is 0 from the fifth cycle on.
- R4: A write with `reg_wdata[0]`=0 while `win_open` is 1 loads `reg_wdata[1]` into `vec_boot` (1 = boot area) and clears `win_open`, both visible in the next cycle.
- R5: A write with `reg_wdata[0]`=0 while `win_open` is 0 is ignored: `vec_boot` and `win_open` keep their values.
- R6: An unlock write while the window is already open restarts the window. `win_open` then stays 1 for 4 full cycles after that write.
- R7: `irq_mask` is 1 in every cycle in which `win_open` is 1.
- R8: With `vec_boot`=1, `lock_app`=1 and `exec_boot`=0 (running from the application area), `irq_mask` is 1.
- R9: With `vec_boot`=0, `lock_boot`=1 and `exec_boot`=1 (running from the boot area), `irq_mask` is 1.
- R10: In every other case with `win_open`=0, `irq_mask` is 0. The mask follows the lock and region inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe of the control register |
| reg_wdata | input | 2 | Write data: bit 0 unlock, bit 1 placement |
| lock_app | input | 1 | Lock that forbids interrupts while running in the application area |
| lock_boot | input | 1 | Lock that forbids interrupts while running in the boot area |
| exec_boot | input | 1 | 1 while the processor executes from the boot area |
| vec_boot | output | 1 | Vector placement: 0 application area, 1 boot area |
| win_open | output | 1 | Change window currently open |
| irq_mask | output | 1 | Global interrupt mask |

## Verification
The embedded properties are checked on every cycle:
- an unlock write always opens the window;
- a closed window never lets the placement move;
- a placement write inside the window closes it;
- the window closes when its count runs out;
- the mask is high whenever the window is open.

The exact window length and the restart on a repeated unlock are shown only by the bench scenarios. The same holds for the mask truth table over all lock, region and placement combinations. The bench compares each of these cycle by cycle against its behavioural model.

// File: rtl/ivg_pkg.sv
// Package ivg_pkg
// Shared encodings for the vector relocation guard.
// Assumes: write data bit positions are fixed by software convention.
package ivg_pkg;
    typedef enum logic {
        VEC_APP  = 1'b0,
        VEC_BOOT = 1'b1
    } vec_loc_t;

    localparam int UNLOCK_BIT = 0;
    localparam int PLACE_BIT  = 1;
    localparam int WDATA_W    = 2;
endpackage

// File: rtl/ivg_window.sv
// Module ivg_window
// Timed change window. An open request (re)starts a window of WINDOW
// cycles. A placement write closes it at once; otherwise it expires.
// Assumes: open_req has priority over sel_wr in the same cycle.
module ivg_window #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_req,
    input  logic sel_wr,
    output logic win_open
);
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt;

    // Window state and countdown of remaining open cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            cnt      <= '0;
        end else if (open_req) begin
            win_open <= 1'b1;
            cnt      <= LAST;
        end else if (win_open && sel_wr) begin
            win_open <= 1'b0;
        end else if (win_open) begin
            if (cnt == '0) win_open <= 1'b0;
            else           cnt      <= cnt - 1'b1;
        end
    end

    // R3
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && cnt == '0 && !open_req) |=> !win_open);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_req |=> (win_open && cnt == LAST));
endmodule

// File: rtl/ivg_select.sv
// Module ivg_select
// Holds the vector placement bit; loads only when the guard grants it.
// Assumes: load is already qualified by an open window.
module ivg_select
    import ivg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  vec_loc_t din,
    output vec_loc_t loc
);
    // Placement register, application area after reset
    always_ff @(posedge clk) begin
        if (!rst_n)    loc <= VEC_APP;
        else if (load) loc <= din;
    end
endmodule

// File: rtl/ivg_mask.sv
// Module ivg_mask
// Combines window state, placement, locks and execution region into
// the global interrupt mask.
// Assumes: all inputs are synchronous to the guard clock.
module ivg_mask
    import ivg_pkg::*;
(
    input  logic     win_open,
    input  vec_loc_t loc,
    input  logic     lock_app,
    input  logic     lock_boot,
    input  logic     exec_boot,
    output logic     irq_mask
);
    logic app_block, boot_block;

    // Lock rule per region, selected by where the vectors sit
    always_comb begin
        app_block  = (loc == VEC_BOOT) && lock_app  && !exec_boot;
        boot_block = (loc == VEC_APP)  && lock_boot &&  exec_boot;
        irq_mask   = win_open || app_block || boot_block;
    end
endmodule

// File: rtl/ivg_guard.sv
// Module ivg_guard
// Top of the vector relocation guard: decodes the write port, drives
// the window timer, the placement register and the mask logic.
// Assumes: one register write per cycle; synchronous active-low reset.
module ivg_guard
    import ivg_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [WDATA_W-1:0] reg_wdata,
    input  logic               lock_app,
    input  logic               lock_boot,
    input  logic               exec_boot,
    output logic               vec_boot,
    output logic               win_open,
    output logic               irq_mask
);
    logic     open_req, sel_wr, load;
    vec_loc_t loc;

    // Write decode: unlock request or placement write
    always_comb begin
        open_req = reg_wr &&  reg_wdata[UNLOCK_BIT];
        sel_wr   = reg_wr && !reg_wdata[UNLOCK_BIT];
        load     = sel_wr && win_open;
        vec_boot = (loc == VEC_BOOT);
    end

    ivg_window #(.WINDOW(WINDOW)) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_req (open_req),
        .sel_wr   (sel_wr),
        .win_open (win_open)
    );

    ivg_select i_select (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (vec_loc_t'(reg_wdata[PLACE_BIT])),
        .loc   (loc)
    );

    ivg_mask i_mask (
        .win_open  (win_open),
        .loc       (loc),
        .lock_app  (lock_app),
        .lock_boot (lock_boot),
        .exec_boot (exec_boot),
        .irq_mask  (irq_mask)
    );

    // R2
    open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[UNLOCK_BIT]) |=> (win_open && $stable(vec_boot)));

    // R5
    closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !(reg_wr && reg_wdata[UNLOCK_BIT])) |=> $stable(vec_boot));

    // R4
    sel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && reg_wr && !reg_wdata[UNLOCK_BIT])
            |=> (!win_open && vec_boot == $past(reg_wdata[PLACE_BIT])));

    // R7
    window_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> irq_mask);
endmodule

// File: tb/test_ivg_guard.sv
module test_ivg_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic       lock_app = 1'b0, lock_boot = 1'b0, exec_boot = 1'b0;
    logic       vec_boot, win_open, irq_mask;

    int    errors = 0, checks = 0, cycles = 0;
    int    m_rem = 0;
    bit    m_sel = 1'b0;
    string cur = "R1";

    always #5 clk = ~clk;

    ivg_guard i_ivg_guard (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .lock_app(lock_app), .lock_boot(lock_boot), .exec_boot(exec_boot),
        .vec_boot(vec_boot), .win_open(win_open), .irq_mask(irq_mask)
    );

    // Behavioural model: remaining window cycles and placement
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_rem = 0; m_sel = 1'b0;
        end else if (reg_wr && reg_wdata[0]) begin
            m_rem = 4;
        end else if (reg_wr && m_rem > 0) begin
            m_sel = reg_wdata[1]; m_rem = 0;
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
        end
    end

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit    en;
        bit    c8, c9, mexp;
        string mtag;
        en   = (m_rem > 0);
        c8   = m_sel && lock_app && !exec_boot;
        c9   = !m_sel && lock_boot && exec_boot;
        mexp = en || c8 || c9;
        mtag = en ? "R7" : (c8 ? "R8" : (c9 ? "R9" : "R10"));
        check(cur, vec_boot, m_sel, "vec_boot");
        check(cur, win_open, en, "win_open");
        check(mtag, irq_mask, mexp, "irq_mask");
    endtask

    task automatic step(bit wr, bit [1:0] d, bit la, bit lb, bit eb);
        @(negedge clk);
        compare();
        reg_wr = wr; reg_wdata = d;
        lock_app = la; lock_boot = lb; exec_boot = eb;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cur = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R5: placement write with window closed is ignored
        cur = "R5";
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        idle(3);
        // R2 then R3: open and let it expire
        cur = "R2";
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        cur = "R3";
        idle(7);
        // R4: open, wait, write boot placement
        cur = "R4";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        idle(3);
        // R6: restart while open
        cur = "R6";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(3);
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(6);
        // R4 at last window cycle: back to application area
        cur = "R4";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(3);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        idle(2);
        // R8 R9 R10: all lock/region combos for both placements
        cur = "R10";
        for (int p = 0; p < 2; p++) begin
            step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
            step(1'b1, {p[0], 1'b0}, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < 8; k++)
                step(1'b0, 2'b00, k[2], k[1], k[0]);
        end
        // R7: window open with locks inactive still masks
        cur = "R7";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(6);
        // R1: reset mid-window returns to defaults
        cur = "R1";
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        idle(1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule